// File: doc/BRIEF.md
# Dual-Port Output Test Pattern Generator

This block sits in front of two 8-bit output ports of a dual-channel converter. Normally it forwards the I-channel sample to port A and the Q-channel sample to port B through a single register stage. When a test is requested, it puts a known pattern on both ports instead, so that board wiring and receiver logic can be checked without a live analog signal.

One 10-bit control word picks the behaviour. Bit 0 turns the test on. Bit 1 chooses how the test drives the ports. In static mode, bits 9..2 form a byte that appears as-is on port B and inverted on port A. In dynamic mode, an internal 8-bit counter drives both ports with the same rising ramp. The control word is loaded on any clock edge where the write strobe is high. It takes effect at the next edge.

Top module: `outtest_gen`

## Requirements
- R1: While `rst` is high, on every clock edge `port_a` and `port_b` become 0 and the stored control word becomes 0, which means the test is off.
- R2: With the test off (stored bit 0 = 0), each clock edge loads `port_a` with the `i_data` value present before that edge and `port_b` with the `q_data` value present before that edge. This is one cycle of latency.
- R3: Stored control bit 0 = 1 replaces the sample data on both ports with test data, and does so with the same one-register latency.
- R4: With the test on and stored bit 1 = 0 (static), `port_b` equals stored bits 9..2 and `port_a` equals their bitwise inverse.
- R5: With the test on and stored bit 1 = 1 (dynamic), `port_a` equals `port_b` and the value rises by 1 on each clock.
- R6: The dynamic ramp wraps from 255 to 0.
- R7: The first dynamic output after entering dynamic mode from any other mode is 0.
- R8: `cfg_word` is stored on a clock edge where `cfg_we` is 1. Outputs reflect the new word from the following edge onward.
- R9: On an edge where `cfg_we` is 0, `cfg_word` is ignored and the stored word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_word | input | 10 | Control word: bit 0 enable, bit 1 dynamic, bits 9..2 static pattern |
| i_data | input | 8 | I-channel sample |
| q_data | input | 8 | Q-channel sample |
| port_a | output | 8 | Output port A (I data or test data) |
| port_b | output | 8 | Output port B (Q data or test data) |

## Verification
A control write and pattern generation can share a cycle. A new word can arrive while the ramp is still running, or while sample data is still being forwarded. The bench provokes this with back-to-back writes that move between static, dynamic and off, and with strobe-low writes placed between live outputs. The scoreboard then expects the old mode for exactly one more edge, and expects the ramp to restart at 0 on each return to dynamic mode.

// File: rtl/outtest_pkg.sv
package outtest_pkg;

    localparam int PIX_W   = 8;
    localparam int CTRL_W  = PIX_W + 2;
    localparam int N_LANES = 2;

    typedef logic [PIX_W-1:0] pix_t;

    // Packed layout follows the control word: [CTRL_W-1:2] pattern, [1] dyn, [0] en
    typedef struct packed {
        pix_t pattern;
        logic dyn;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_PASS   = 2'd0,
        SRC_STATIC = 2'd1,
        SRC_RAMP   = 2'd2
    } src_e;

    // Lane 0 feeds port A, lane 1 feeds port B
    typedef struct packed {
        pix_t lane_b;
        pix_t lane_a;
    } pair_t;

    function automatic src_e pick_src(ctrl_t c);
        if (!c.en)
            return SRC_PASS;
        else if (c.dyn)
            return SRC_RAMP;
        else
            return SRC_STATIC;
    endfunction

    function automatic logic ramp_active(ctrl_t c);
        return c.en & c.dyn;
    endfunction

endpackage

// File: rtl/outtest_ctrl_reg.sv
module outtest_ctrl_reg
    import outtest_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_word,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_word;
    end

endmodule

// File: rtl/outtest_ramp.sv
module outtest_ramp
    import outtest_pkg::*;
#(
    parameter int STEP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output pix_t value
);

    localparam pix_t STEP_V = pix_t'(STEP);

    // Held at zero whenever the ramp is idle, so every entry starts from 0
    always_ff @(posedge clk) begin
        if (rst || !run)
            value <= '0;
        else
            value <= value + STEP_V;
    end

endmodule

// File: rtl/outtest_select.sv
module outtest_select
    import outtest_pkg::*;
(
    input  ctrl_t ctrl,
    input  pix_t  i_data,
    input  pix_t  q_data,
    input  pix_t  ramp,
    output pair_t nxt
);

    src_e src;

    always_comb begin
        src = pick_src(ctrl);
        unique case (src)
            SRC_STATIC: begin
                nxt.lane_b = ctrl.pattern;
                nxt.lane_a = ~ctrl.pattern;
            end
            SRC_RAMP: begin
                nxt.lane_b = ramp;
                nxt.lane_a = ramp;
            end
            default: begin
                nxt.lane_b = q_data;
                nxt.lane_a = i_data;
            end
        endcase
    end

endmodule

// File: rtl/outtest_gen.sv
module outtest_gen
    import outtest_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_word,
    input  logic [PIX_W-1:0]  i_data,
    input  logic [PIX_W-1:0]  q_data,
    output logic [PIX_W-1:0]  port_a,
    output logic [PIX_W-1:0]  port_b
);

    ctrl_t ctrl_q;
    pix_t  ramp_v;
    pair_t nxt;
    pix_t  lane_d [N_LANES];
    pix_t  lane_q [N_LANES];

    outtest_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_word (ctrl_t'(cfg_word)),
        .ctrl_q  (ctrl_q)
    );

    outtest_ramp #(.STEP(1)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .run   (ramp_active(ctrl_q)),
        .value (ramp_v)
    );

    outtest_select u_sel (
        .ctrl   (ctrl_q),
        .i_data (i_data),
        .q_data (q_data),
        .ramp   (ramp_v),
        .nxt    (nxt)
    );

    assign lane_d[0] = nxt.lane_a;
    assign lane_d[1] = nxt.lane_b;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else
                lane_q[g] <= lane_d[g];
        end
    end

    assign port_a = lane_q[0];
    assign port_b = lane_q[1];

endmodule

// File: rtl/outtest_gen_chk.sv
module outtest_gen_chk
    import outtest_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CTRL_W-1:0] cfg_word,
    input logic [PIX_W-1:0]  i_data,
    input logic [PIX_W-1:0]  q_data,
    input logic [PIX_W-1:0]  port_a,
    input logic [PIX_W-1:0]  port_b,
    input ctrl_t             ctrl
);

    // R1
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (port_a == '0 && port_b == '0 && ctrl == '0));

    // R2
    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> (port_a == $past(i_data) && port_b == $past(q_data)));

    // R3, R4
    p_static_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !ctrl.dyn) |=> (port_b == $past(ctrl.pattern) && port_a == ~port_b));

    // R5
    p_ramp_same_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.dyn) |=> (port_a == port_b));

    // R5, R6
    p_ramp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.dyn && $past(ctrl.en && ctrl.dyn))
        |=> (port_b == PIX_W'($past(port_b) + 1'b1)));

    // R7
    p_ramp_start_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.dyn && !$past(ctrl.en && ctrl.dyn)) |=> (port_b == '0));

    // R8
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (ctrl == ctrl_t'($past(cfg_word))));

    // R9
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(ctrl));

endmodule

bind outtest_gen outtest_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .i_data   (i_data),
    .q_data   (q_data),
    .port_a   (port_a),
    .port_b   (port_b),
    .ctrl     (ctrl_q)
);

// File: tb/tb_outtest_gen.sv
module tb_outtest_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_word = '0;
    logic [7:0] i_data = '0;
    logic [7:0] q_data = '0;
    logic [7:0] port_a;
    logic [7:0] port_b;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // Reference state kept from the requirements alone
    logic [9:0] m_ctrl = '0;
    logic [7:0] m_ramp = '0;
    bit         m_was_dyn = 1'b0;
    bit         m_wrote = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    outtest_gen dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .i_data   (i_data),
        .q_data   (q_data),
        .port_a   (port_a),
        .port_b   (port_b)
    );

    task automatic report(string tag, logic [7:0] aa, logic [7:0] ab,
                          logic [7:0] ea, logic [7:0] eb);
        checks++;
        if (aa !== ea || ab !== eb) begin
            failures++;
            $display("FAIL %s: port_a=%02h port_b=%02h expected port_a=%02h port_b=%02h",
                     tag, aa, ab, ea, eb);
        end
    endtask

    // Driver: one cycle of stimulus, with its expected result queued
    task automatic step(bit we, logic [9:0] word, logic [7:0] iv, logic [7:0] qv,
                        string tag_ovr);
        exp_t e;
        bit   dyn_now;
        @(negedge clk);
        cfg_we   = we;
        cfg_word = word;
        i_data   = iv;
        q_data   = qv;
        dyn_now  = m_ctrl[0] && m_ctrl[1];
        if (!m_ctrl[0]) begin
            e.a = iv; e.b = qv; e.tag = "R2";
        end else if (!m_ctrl[1]) begin
            e.b = m_ctrl[9:2]; e.a = ~m_ctrl[9:2]; e.tag = "R4";
        end else begin
            e.a = m_ramp; e.b = m_ramp;
            if (!m_was_dyn)          e.tag = "R7";
            else if (m_ramp == 8'd0) e.tag = "R6";
            else                     e.tag = "R5";
        end
        if (m_wrote) e.tag = {"R8 ", e.tag};
        if (tag_ovr != "") e.tag = tag_ovr;
        sb.push_back(e);
        m_ramp    = dyn_now ? m_ramp + 8'd1 : 8'd0;
        m_was_dyn = dyn_now;
        m_wrote   = we;
        if (we) m_ctrl = word;
    endtask

    // Monitor: compare each output edge against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                report(e.tag, port_a, port_b, e.a, e.b);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                failures++;
                checks++;
                $display("FAIL watchdog: timeout actual=%0d expected<=20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        report("R1", port_a, port_b, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: pass-through with varied samples
        for (int k = 0; k < 12; k++)
            step(1'b0, 10'h000, 8'(k * 37 + 5), 8'(8'hFF - k * 19), "");

        // R9: strobe low, words that would enable tests are ignored
        step(1'b0, {8'hA5, 2'b01}, 8'h11, 8'h22, "");
        step(1'b0, {8'h3C, 2'b11}, 8'h33, 8'h44, "R9");
        step(1'b0, 10'h3FF, 8'h55, 8'h66, "R9");

        // R8, R3: write static pattern; old mode lasts one more edge
        step(1'b1, {8'hA5, 2'b01}, 8'h77, 8'h88, "");
        step(1'b0, 10'h000, 8'h99, 8'hAA, "R3");
        step(1'b0, 10'h000, 8'hBB, 8'hCC, "");
        // R4: other patterns, including extremes
        step(1'b1, {8'h00, 2'b01}, 8'h01, 8'h02, "");
        step(1'b0, 10'h000, 8'h03, 8'h04, "");
        step(1'b1, {8'hFF, 2'b01}, 8'h05, 8'h06, "");
        step(1'b0, 10'h000, 8'h07, 8'h08, "");
        step(1'b1, {8'h5A, 2'b01}, 8'h09, 8'h0A, "");
        step(1'b0, 10'h3FE, 8'h0B, 8'h0C, "");

        // R5, R6, R7: dynamic ramp long enough to wrap
        step(1'b1, {8'h12, 2'b11}, 8'h0D, 8'h0E, "");
        for (int k = 0; k < 300; k++)
            step(1'b0, 10'(k), 8'(k), 8'(~k), "");

        // Pattern rewrite while dynamic keeps ramp running
        step(1'b1, {8'hC3, 2'b11}, 8'h10, 8'h20, "");
        for (int k = 0; k < 5; k++)
            step(1'b0, 10'h000, 8'h30, 8'h40, "");

        // R7: leave to static, then re-enter dynamic
        step(1'b1, {8'h81, 2'b01}, 8'h50, 8'h60, "");
        step(1'b0, 10'h000, 8'h51, 8'h61, "");
        step(1'b1, {8'h81, 2'b11}, 8'h52, 8'h62, "");
        for (int k = 0; k < 6; k++)
            step(1'b0, 10'h000, 8'h53, 8'h63, "");

        // Leave dynamic straight to off, then re-enter from off
        step(1'b1, 10'h000, 8'hE1, 8'hE2, "");
        for (int k = 0; k < 4; k++)
            step(1'b0, 10'h3FF, 8'(8'hF0 + k), 8'(8'h0F + k), "");
        step(1'b1, 10'h003, 8'h70, 8'h71, "");
        for (int k = 0; k < 4; k++)
            step(1'b0, 10'h000, 8'h72, 8'h73, "");

        // Final return to pass-through
        step(1'b1, 10'h000, 8'hAB, 8'hCD, "");
        for (int k = 0; k < 4; k++)
            step(1'b0, 10'h000, 8'(8'h40 + k), 8'(8'h80 + k), "");

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule